// File: doc/BRIEF.md
# Block-Counted Word/Byte FIFO Packer

This block sits between a 32-bit software-facing data port and a byte-wide card data stream. A sixteen-word circular FIFO buffers data in both directions. A transfer is armed by pulsing a load strobe, which sets a remaining-byte counter to the block count times the block length. The direction input then selects one of two paths. In card-to-host transfers, incoming bytes are packed into words and pushed into the FIFO, and software drains the words. In host-to-card transfers, software fills the FIFO with words, and the block unpacks them into outgoing bytes.

Both byte streams use valid/ready. A byte moves only on a cycle where valid and ready are both high. The input stream is back-pressured: `cin_ready_o` drops while the FIFO is full, when no bytes remain, or in host-to-card mode. The output stream only offers a byte when one is available: `cout_valid_o` stays low when the FIFO is empty and no unsent bytes of a popped word are held. The sink may hold `cout_ready_i` low for any length of time, and the byte stays stable until it is taken. The word port is plain: a push is a single-cycle strobe, a pop is a single-cycle strobe, and the read data shows the FIFO head combinationally.

The block reports the fill level, the remaining count and a 4-bit mode field. It also keeps two sticky flags: a data flag for word traffic and a block flag for block boundaries in host-to-card transfers. Each flag is cleared by writing a one to its bit of `stat_clr_i`.

Top module: `blk_fifo_packer`

## Requirements
- R1: After reset, the fill level, the remaining count, the mode field (0x0), both sticky flags, `cin_ready_o` and `cout_valid_o` are all zero.
- R2: A `cnt_load_i` pulse sets `rem_o` to `blk_cnt_i * blk_len_i` on the next cycle. The mode field becomes 0x1 (data mode) if that product is zero, and 0x0 otherwise. The pulse also discards any partly packed or unpacked word.
- R3: The FIFO holds 16 words in first-in first-out order, and `fill_o` reports 0 to 16. A push arriving while the FIFO is full is dropped.
- R4: A pop while the FIFO is empty leaves the fill level at zero, and `sw_rdata_o` reads zero while the FIFO is empty.
- R5: In card-to-host mode (`dir_write_i`=0), the bytes accepted for one word land at bit offsets 0, 8, 16 and 24 in arrival order. The word is pushed once its fourth byte is accepted.
- R6: When the remaining count runs out partway through a word, that word is pushed at once, and its unfilled upper bytes are zero.
- R7: `cin_ready_o` is low whenever the FIFO is full, the remaining count is zero, or the block is in host-to-card mode.
- R8: In host-to-card mode (`dir_write_i`=1), each popped word leaves as four bytes, bits 7:0 first and bits 31:24 last. Every byte transferred in either direction lowers `rem_o` by one.
- R9: `cout_valid_o` is low when the remaining count is zero. It is also low when the FIFO is empty and no bytes of a popped word are pending.
- R10: The mode field becomes 0x1 on the cycle after the last counted byte moves.
- R11: In host-to-card mode with a nonzero block length and `blk_irq_en_i` high, `blk_irq_o` sets each time the remaining count reaches a multiple of the block length. The block length used is the one sampled at load. The flag is never set in card-to-host mode or while the enable is low. It is cleared by `stat_clr_i[1]`.
- R12: `data_flag_o` sets whenever the engine pushes a packed word or pops a word to unpack, and is cleared by `stat_clr_i[0]`.
- R13: Software pushes are ignored in card-to-host mode, and software pops are ignored in host-to-card mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_write_i | input | 1 | 1 = host-to-card, 0 = card-to-host |
| blk_len_i | input | 12 | Block length in bytes |
| blk_cnt_i | input | 9 | Number of blocks |
| cnt_load_i | input | 1 | Load strobe for the remaining count |
| blk_irq_en_i | input | 1 | Enables the block flag |
| stat_clr_i | input | 2 | Write-one-to-clear: bit 0 data flag, bit 1 block flag |
| sw_push_i | input | 1 | Software word push strobe |
| sw_wdata_i | input | 32 | Word to push |
| sw_pop_i | input | 1 | Software word pop strobe |
| sw_rdata_o | output | 32 | FIFO head, zero when empty |
| cin_valid_i | input | 1 | Card byte valid |
| cin_data_i | input | 8 | Card byte |
| cin_ready_o | output | 1 | Card byte accepted when high with valid |
| cout_valid_o | output | 1 | Outgoing byte valid |
| cout_data_o | output | 8 | Outgoing byte |
| cout_ready_i | input | 1 | Sink accepts the outgoing byte |
| fill_o | output | 5 | FIFO fill level |
| rem_o | output | 21 | Remaining byte count |
| mode_o | output | 4 | Mode field, 0x1 = data mode |
| data_flag_o | output | 1 | Sticky data flag |
| blk_irq_o | output | 1 | Sticky block flag |

## Verification
Card-to-host runs use three totals:
- An exact 5-byte count checks zero padding of the last word.
- An 80-byte count overruns the FIFO. It shows that the input stalls at sixteen words and resumes once words are drained.
- A 21-byte count mixes full and partial words.

All runs use random valid gaps. Host-to-card runs push random words against a randomly stalling sink, with block lengths of 4, 6 and 7:
- Length 4 places block boundaries on word boundaries, and length 6 places them mid-word.
- The length-7 run has the enable off.

Directed cases cover overfilling the FIFO, popping it empty, strobes in the wrong direction, and a zero-size load.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    MODE_IDLE = 4'h0,
    MODE_DATA = 4'h1
  } xfer_mode_e;
endpackage

// File: rtl/fp_word_fifo.sv
module fp_word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DW-1:0]            push_data,
  input  logic                     pop,
  output logic [DW-1:0]            head,
  output logic [$clog2(DEPTH):0]   fill,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr;
  logic [AW-1:0] wptr;
  logic          do_push;
  logic          do_pop;

  assign full    = (fill == (AW+1)'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign wptr    = rptr + fill[AW-1:0];
  assign head    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      fill <= '0;
    end else begin
      if (do_pop) rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (fill == $past(fill)));
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (fill == '0));
endmodule

// File: rtl/fp_rx_pack.sv
module fp_rx_pack #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          fifo_full,
  input  logic          last,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          take,
  output logic          push,
  output logic [DW-1:0] word
);
  localparam int BPW = DW / fp_pkg::BYTE_W;
  localparam int IW  = $clog2(BPW);

  logic [DW-1:0] acc;
  logic [IW-1:0] idx;

  assign in_ready = en && !fifo_full;
  assign take     = in_valid && in_ready;
  assign push     = take && ((idx == IW'(BPW-1)) || last);

  always_comb begin
    word = acc;
    word[{idx, 3'b000} +: 8] = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      idx <= '0;
    end else if (clr || push) begin
      acc <= '0;
      idx <= '0;
    end else if (take) begin
      acc <= word;
      idx <= idx + 1'b1;
    end
  end

  p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !fifo_full);
endmodule

// File: rtl/fp_tx_unpack.sv
module fp_tx_unpack #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          fifo_empty,
  input  logic [DW-1:0] head,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          take,
  output logic          pop
);
  localparam int BPW = DW / fp_pkg::BYTE_W;
  localparam int LW  = $clog2(BPW) + 1;

  logic [DW-1:0] sh;
  logic [LW-1:0] left;

  assign out_valid = en && ((left != '0) || !fifo_empty);
  assign out_data  = (left != '0) ? sh[7:0] : head[7:0];
  assign take      = out_valid && out_ready;
  assign pop       = take && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (clr) begin
      sh   <= '0;
      left <= '0;
    end else if (take) begin
      if (left == '0) begin
        sh   <= head >> 8;
        left <= LW'(BPW-1);
      end else begin
        sh   <= sh >> 8;
        left <= left - 1'b1;
      end
    end
  end

  p_hold_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/blk_fifo_packer.sv
module blk_fifo_packer
  import fp_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int BLEN_W = 12,
  parameter int BCNT_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dir_write_i,
  input  logic [BLEN_W-1:0]         blk_len_i,
  input  logic [BCNT_W-1:0]         blk_cnt_i,
  input  logic                      cnt_load_i,
  input  logic                      blk_irq_en_i,
  input  logic [1:0]                stat_clr_i,
  input  logic                      sw_push_i,
  input  logic [DW-1:0]             sw_wdata_i,
  input  logic                      sw_pop_i,
  output logic [DW-1:0]             sw_rdata_o,
  input  logic                      cin_valid_i,
  input  logic [7:0]                cin_data_i,
  output logic                      cin_ready_o,
  output logic                      cout_valid_o,
  output logic [7:0]                cout_data_o,
  input  logic                      cout_ready_i,
  output logic [$clog2(DEPTH):0]    fill_o,
  output logic [BLEN_W+BCNT_W-1:0]  rem_o,
  output logic [3:0]                mode_o,
  output logic                      data_flag_o,
  output logic                      blk_irq_o
);
  localparam int REM_W = BLEN_W + BCNT_W;

  logic [REM_W-1:0]  rem;
  logic [BLEN_W-1:0] blen_q;
  logic [BLEN_W-1:0] blk_left;
  xfer_mode_e        mode;

  logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DW-1:0] fifo_wdata, fifo_head;
  logic          rx_take, rx_push, tx_take, tx_pop;
  logic [DW-1:0] rx_word;
  logic          byte_take, blk_tick;
  logic [REM_W-1:0] load_val;

  assign fifo_push  = dir_write_i ? sw_push_i : rx_push;
  assign fifo_wdata = dir_write_i ? sw_wdata_i : rx_word;
  assign fifo_pop   = dir_write_i ? tx_pop : sw_pop_i;

  fp_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .push_data(fifo_wdata), .pop(fifo_pop),
    .head(fifo_head), .fill(fill_o), .full(fifo_full), .empty(fifo_empty)
  );

  fp_rx_pack #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(cnt_load_i),
    .en(!dir_write_i && (rem != '0)), .fifo_full(fifo_full),
    .last(rem == REM_W'(1)),
    .in_valid(cin_valid_i), .in_data(cin_data_i), .in_ready(cin_ready_o),
    .take(rx_take), .push(rx_push), .word(rx_word)
  );

  fp_tx_unpack #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(cnt_load_i),
    .en(dir_write_i && (rem != '0)), .fifo_empty(fifo_empty),
    .head(fifo_head), .out_ready(cout_ready_i),
    .out_valid(cout_valid_o), .out_data(cout_data_o),
    .take(tx_take), .pop(tx_pop)
  );

  assign sw_rdata_o = fifo_head;
  assign byte_take  = rx_take || tx_take;
  assign load_val   = REM_W'(blk_cnt_i) * REM_W'(blk_len_i);
  assign blk_tick   = tx_take && (blen_q != '0) && (blk_left == BLEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      blen_q   <= '0;
      blk_left <= '0;
      mode     <= MODE_IDLE;
    end else if (cnt_load_i) begin
      rem      <= load_val;
      blen_q   <= blk_len_i;
      blk_left <= blk_len_i;
      mode     <= (load_val == '0) ? MODE_DATA : MODE_IDLE;
    end else if (byte_take) begin
      rem <= rem - 1'b1;
      if (rem == REM_W'(1)) mode <= MODE_DATA;
      if (tx_take) blk_left <= (blk_left == BLEN_W'(1)) ? blen_q : blk_left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_flag_o <= 1'b0;
      blk_irq_o   <= 1'b0;
    end else begin
      data_flag_o <= (data_flag_o && !stat_clr_i[0]) || rx_push || tx_pop;
      blk_irq_o   <= (blk_irq_o && !stat_clr_i[1]) || (blk_tick && blk_irq_en_i);
    end
  end

  assign rem_o  = rem;
  assign mode_o = mode;

  p_rem_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && !cnt_load_i) |=> (rem_o == $past(rem_o) - 1'b1));
  p_mode_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_take && !cnt_load_i && rem_o == REM_W'(1)) |=> (mode_o == 4'h1));
  p_dir_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cin_ready_o && cout_valid_o));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_o == '0) |-> (!cout_valid_o && !cin_ready_o));
  p_no_rx_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_write_i && !blk_irq_o) |=> !blk_irq_o);
endmodule

// File: tb/sim_blk_fifo_packer.sv
`timescale 1ns/1ps
module sim_blk_fifo_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_write = 1'b0;
  logic [11:0] blk_len = '0;
  logic [8:0]  blk_cnt = '0;
  logic        cnt_load = 1'b0;
  logic        irq_en = 1'b0;
  logic [1:0]  stat_clr = '0;
  logic        sw_push = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        sw_pop = 1'b0;
  logic [31:0] sw_rdata;
  logic        cin_valid = 1'b0;
  logic [7:0]  cin_data = '0;
  logic        cin_ready;
  logic        cout_valid;
  logic [7:0]  cout_data;
  logic        cout_ready = 1'b0;
  logic [4:0]  fill;
  logic [20:0] rem;
  logic [3:0]  mode;
  logic        data_flag, blk_irq;

  int checks = 0;
  int errors = 0;
  logic [7:0]  bytes [0:1023];
  logic [31:0] words [0:255];
  logic [31:0] ref_words [0:15];

  always #2 clk = ~clk;

  blk_fifo_packer u0 (
    .clk(clk), .rst_n(rst_n), .dir_write_i(dir_write), .blk_len_i(blk_len),
    .blk_cnt_i(blk_cnt), .cnt_load_i(cnt_load), .blk_irq_en_i(irq_en),
    .stat_clr_i(stat_clr), .sw_push_i(sw_push), .sw_wdata_i(sw_wdata),
    .sw_pop_i(sw_pop), .sw_rdata_o(sw_rdata), .cin_valid_i(cin_valid),
    .cin_data_i(cin_data), .cin_ready_o(cin_ready), .cout_valid_o(cout_valid),
    .cout_data_o(cout_data), .cout_ready_i(cout_ready), .fill_o(fill),
    .rem_o(rem), .mode_o(mode), .data_flag_o(data_flag), .blk_irq_o(blk_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load(input logic d, input int len, input int cnt);
    dir_write = d;
    blk_len   = 12'(len);
    blk_cnt   = 9'(cnt);
    cnt_load  = 1'b1;
    step();
    cnt_load  = 1'b0;
  endtask

  task automatic clear_flags();
    stat_clr = 2'b11;
    step();
    stat_clr = 2'b00;
  endtask

  function automatic logic [31:0] exp_rx_word(input int k, input int total);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++)
      if (4*k + i < total) w[8*i +: 8] = bytes[4*k + i];
    return w;
  endfunction

  task automatic rx_run(input int len, input int cnt);
    int total = len * cnt;
    int nb = 0;
    int np = 0;
    int nw = (total + 3) / 4;
    int guard = 0;
    bit full_seen = 0;
    load(1'b0, len, cnt);
    chk("R2 load count", 32'(rem), 32'(total));
    while (np < nw && guard < 20000) begin
      guard++;
      cin_valid = (nb < total) && ($urandom % 4 != 0);
      cin_data  = 8'($urandom);
      sw_pop    = !(nb < total && fill < 5'd16) && (fill != 0) && ($urandom % 2 == 1);
      #1;
      if (fill == 5'd16 && nb < total && !full_seen) begin
        full_seen = 1;
        chk("R7 ready low when full", 32'(cin_ready), 32'd0);
      end
      if (cin_valid && cin_ready) begin
        bytes[nb] = cin_data;
        nb++;
      end
      if (sw_pop && fill != 0) begin
        chk("R5/R6 packed word", sw_rdata, exp_rx_word(np, total));
        np++;
      end
      step();
    end
    cin_valid = 1'b0;
    sw_pop    = 1'b0;
    #1;
    chk("R8 rem zero after rx", 32'(rem), 32'd0);
    chk("R10 data mode after rx", 32'(mode), 32'h1);
    chk("R7 ready low at zero count", 32'(cin_ready), 32'd0);
    chk("R3 fifo drained", 32'(fill), 32'd0);
  endtask

  task automatic tx_run(input int len, input int cnt, input logic en);
    int total = len * cnt;
    int nb = 0;
    int nwp = 0;
    int guard = 0;
    logic irq_m = 1'b0;
    logic [31:0] w;
    irq_en = en;
    clear_flags();
    load(1'b1, len, cnt);
    chk("R9 no valid with empty fifo", 32'(cout_valid), 32'd0);
    while (nb < total && guard < 20000) begin
      guard++;
      sw_push    = (nwp * 4 < total) && ($urandom % 2 == 1);
      sw_wdata   = $urandom;
      cout_ready = ($urandom % 3 != 0);
      #1;
      if (sw_push && fill < 5'd16) begin
        words[nwp] = sw_wdata;
        nwp++;
      end
      if (cout_valid && cout_ready) begin
        w = words[nb / 4];
        chk("R8 unpacked byte", 32'(cout_data), 32'(w[8*(nb % 4) +: 8]));
        nb++;
        if (en && (nb % len == 0)) irq_m = 1'b1;
        step();
        chk("R11 block flag", 32'(blk_irq), 32'(irq_m));
      end else begin
        step();
      end
    end
    sw_push    = 1'b0;
    cout_ready = 1'b0;
    #1;
    chk("R9 valid low at zero count", 32'(cout_valid), 32'd0);
    chk("R10 data mode after tx", 32'(mode), 32'h1);
    chk("R8 rem zero after tx", 32'(rem), 32'd0);
    chk("R12 data flag set", 32'(data_flag), 32'd1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    #9;
    chk("R1 fill", 32'(fill), 32'd0);
    chk("R1 rem", 32'(rem), 32'd0);
    chk("R1 mode", 32'(mode), 32'd0);
    chk("R1 flags", {30'd0, data_flag, blk_irq}, 32'd0);
    chk("R1 handshakes", {30'd0, cin_ready, cout_valid}, 32'd0);
    rst_n = 1'b1;
    step();

    load(1'b1, 0, 5);
    chk("R2 zero load data mode", 32'(mode), 32'h1);
    for (int i = 0; i < 17; i++) begin
      sw_push  = 1'b1;
      sw_wdata = $urandom;
      if (i < 16) ref_words[i] = sw_wdata;
      step();
    end
    sw_push = 1'b0;
    chk("R3 full at sixteen", 32'(fill), 32'd16);
    sw_pop = 1'b1;
    step();
    step();
    sw_pop = 1'b0;
    chk("R13 pop ignored in write mode", 32'(fill), 32'd16);
    dir_write = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sw_pop = 1'b1;
      #1;
      chk("R3 fifo order", sw_rdata, ref_words[i]);
      step();
    end
    sw_pop = 1'b0;
    #1;
    chk("R4 empty head zero", sw_rdata, 32'd0);
    sw_pop = 1'b1;
    step();
    sw_pop = 1'b0;
    chk("R4 pop empty keeps fill", 32'(fill), 32'd0);
    sw_push  = 1'b1;
    sw_wdata = 32'hDEADBEEF;
    step();
    sw_push = 1'b0;
    chk("R13 push ignored in read mode", 32'(fill), 32'd0);

    load(1'b0, 8, 2);
    chk("R2 nonzero load mode", 32'(mode), 32'h0);
    chk("R2 nonzero load count", 32'(rem), 32'd16);

    irq_en = 1'b1;
    clear_flags();
    rx_run(5, 1);
    rx_run(10, 8);
    rx_run(3, 7);
    chk("R11 no block flag in read mode", 32'(blk_irq), 32'd0);
    chk("R12 data flag after rx", 32'(data_flag), 32'd1);

    tx_run(4, 5, 1'b1);
    tx_run(6, 3, 1'b1);
    tx_run(7, 3, 1'b0);
    chk("R11 no block flag when disabled", 32'(blk_irq), 32'd0);
    clear_flags();
    chk("R12 data flag cleared", 32'(data_flag), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule